// File: doc/BRIEF.md
# Paged Parallel EEPROM Emulator

This block behaves like a byte-wide parallel EEPROM behind an asynchronous strobe bus. The bus has an active-low chip select, an active-low write strobe, an active-low output enable, an address and a split tri-state data port (`data_in`, `data_out`, `data_drive`). All bus inputs are registered in the system clock domain before any decision is made. The address splits into a 6-bit byte-in-page field (low bits) and a row field above it. The default row width gives a small 2048-byte array for elaboration. A row width of 9 gives the full 32768-byte organisation.

Byte writes are collected into a 64-entry page buffer. Loading stays open while writes keep arriving inside a load window. Once the window passes with no accepted write, a timed programming interval starts. At the end of that interval the loaded bytes are written into the array together, and the buffer's valid mask clears. While programming is in progress, a read returns a status byte instead of array contents.

The controller has three states. In IDLE it waits for a write. The first write moves it to LOAD (transition "first byte"). Writes to the same row keep it in LOAD and restart the window ("reload"). A quiet window moves it to PROG ("load timeout"). When the programming count expires it returns to IDLE ("commit").

Top module: `eep_page_emu`

## Requirements
- R1: With select low, write strobe high and output enable low, `data_drive` is 1. Outside the programming interval, `data_out` then equals the array byte at `bus_addr`.
- R2: `data_drive` is 0 whenever select is high, and whenever the write strobe and output enable are both high.
- R3: A write is a period with select low, write strobe low and output enable high. Its address and data are taken at the end of that period. The end may come from the write strobe rising or from select rising.
- R4: A single page write can load anywhere from 1 to 64 bytes of one row, each at address bits [5:0]. All of them reach the array. When a byte position is written twice, the later value wins.
- R5: Programming begins only after LOAD_CYC clock cycles with no accepted write. Until then, reads still return old array data.
- R6: During programming, bit 7 of a read equals the complement of bit 7 of the last accepted byte. Bits 5..0 read as 0.
- R7: During programming, bit 6 reads 0 on the first read. It inverts after each completed read.
- R8: After PROG_CYC cycles of programming, reads return array data again. The page buffer mask is cleared, so a later page write to another row stores only its own bytes.
- R9: While loading, a write whose row (address bits above bit 5) differs from the first byte's row is ignored. It does not restart the load window.
- R10: A write issued during programming is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Active-low chip select |
| wr_en_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| bus_addr | input | ROW_W+6 | Byte address; bits [5:0] select the byte within a page |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data or programming status |
| data_drive | output | 1 | High when the block drives the data bus |

## Verification
The hardest conditions to reach from the ports are the two kinds of ignored writes. One is a write to a foreign row while the load window is still open. The other is a write that lands inside the programming interval. Both leave no trace unless the stimulus is timed against LOAD_CYC and PROG_CYC. The bench places the stray write right after the first accepted byte, and the late write between status polls. It then reads the targeted addresses after the commit, to show that their old contents survived. Toggle and polling bits are also sampled across several consecutive reads in each programming window. Random rows, byte counts, positions and data are mixed with these directed cases.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOAD = 2'd1,
        S_PROG = 2'd2
    } eep_state_e;
endpackage

// File: rtl/eep_bus_sampler.sv
module eep_bus_sampler #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        data_in,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] evt_addr,
    output logic [7:0]        evt_dq,
    output logic              rd_end
);
    logic              s_cs_n, s_we_n, s_oe_n;
    logic [ADDR_W-1:0] s_addr;
    logic [7:0]        s_dq;
    logic              wr_now, rd_now, wr_d, rd_d;

    assign wr_now = !s_cs_n && !s_we_n && s_oe_n;
    assign rd_now = !s_cs_n && s_we_n && !s_oe_n;
    assign wr_evt = wr_d && !wr_now;
    assign rd_end = rd_d && !rd_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_cs_n   <= 1'b1;
            s_we_n   <= 1'b1;
            s_oe_n   <= 1'b1;
            s_addr   <= '0;
            s_dq     <= '0;
            wr_d     <= 1'b0;
            rd_d     <= 1'b0;
            evt_addr <= '0;
            evt_dq   <= '0;
        end else begin
            s_cs_n <= chip_sel_n;
            s_we_n <= wr_en_n;
            s_oe_n <= out_en_n;
            s_addr <= bus_addr;
            s_dq   <= data_in;
            wr_d   <= wr_now;
            rd_d   <= rd_now;
            if (wr_now) begin
                evt_addr <= s_addr;
                evt_dq   <= s_dq;
            end
        end
    end
endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
    import eep_pkg::*;
#(
    parameter int ROW_W    = 5,
    parameter int PAGE_W   = 6,
    parameter int LOAD_CYC = 20,
    parameter int PROG_CYC = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_evt,
    input  logic [ROW_W+PAGE_W-1:0]       evt_addr,
    input  logic [7:0]                    evt_dq,
    input  logic                          rd_end,
    output eep_state_e                    st,
    output logic [ROW_W-1:0]              cur_row,
    output logic [(1<<PAGE_W)-1:0]        mask,
    output logic [(1<<PAGE_W)-1:0][7:0]   pbuf,
    output logic                          last_b7,
    output logic                          tog,
    output logic                          commit,
    output logic                          accept
);
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int MAXC   = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);

    eep_state_e        nxt;
    logic [CNT_W-1:0]  cnt;
    logic [ROW_W-1:0]  evt_row;
    logic [PAGE_W-1:0] evt_col;
    logic              load_done;

    assign evt_row = evt_addr[ROW_W+PAGE_W-1:PAGE_W];
    assign evt_col = evt_addr[PAGE_W-1:0];

    // output / decision process
    always_comb begin
        accept    = wr_evt && ((st == S_IDLE) || ((st == S_LOAD) && (evt_row == cur_row)));
        load_done = (st == S_LOAD) && !accept && (cnt == CNT_W'(LOAD_CYC - 1));
        commit    = (st == S_PROG) && (cnt == CNT_W'(PROG_CYC - 1));
        nxt       = st;
        unique case (st)
            S_IDLE:  if (accept)    nxt = S_LOAD;   // first byte
            S_LOAD:  if (load_done) nxt = S_PROG;   // load timeout (reload stays)
            S_PROG:  if (commit)    nxt = S_IDLE;   // commit
            default: nxt = S_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cur_row <= '0;
            mask    <= '0;
            last_b7 <= 1'b0;
            tog     <= 1'b0;
        end else begin
            cnt <= (nxt != st || accept) ? '0 : cnt + 1'b1;
            if (accept) begin
                last_b7 <= evt_dq[7];
                if (st == S_IDLE) begin
                    cur_row <= evt_row;
                    mask    <= PAGE_N'(1) << evt_col;
                end else begin
                    mask    <= mask | (PAGE_N'(1) << evt_col);
                end
            end
            if (commit) mask <= '0;
            if (load_done)                    tog <= 1'b0;
            else if ((st == S_PROG) && rd_end) tog <= ~tog;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) pbuf[evt_col] <= evt_dq;
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ROW_W  = 5,
    parameter int PAGE_W = 6
) (
    input  logic                         clk,
    input  logic                         commit,
    input  logic [ROW_W-1:0]             row,
    input  logic [(1<<PAGE_W)-1:0]       mask,
    input  logic [(1<<PAGE_W)-1:0][7:0]  pbuf,
    input  logic [ROW_W+PAGE_W-1:0]      rd_addr,
    output logic [7:0]                   rd_data
);
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int DEPTH  = 1 << (ROW_W + PAGE_W);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (mask[i]) mem[{row, PAGE_W'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_page_emu.sv
module eep_page_emu
    import eep_pkg::*;
#(
    parameter int ROW_W    = 5,
    parameter int LOAD_CYC = 20,
    parameter int PROG_CYC = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chip_sel_n,
    input  logic                  wr_en_n,
    input  logic                  out_en_n,
    input  logic [ROW_W+6-1:0]    bus_addr,
    input  logic [7:0]            data_in,
    output logic [7:0]            data_out,
    output logic                  data_drive
);
    localparam int PAGE_W = 6;
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int ADDR_W = ROW_W + PAGE_W;

    logic                     wr_evt, rd_end, last_b7, tog, commit, accept;
    logic [ADDR_W-1:0]        evt_addr;
    logic [7:0]               evt_dq, arr_q;
    eep_state_e               st;
    logic [ROW_W-1:0]         cur_row;
    logic [PAGE_N-1:0]        mask;
    logic [PAGE_N-1:0][7:0]   pbuf;

    eep_bus_sampler #(.ADDR_W(ADDR_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
        .out_en_n(out_en_n), .bus_addr(bus_addr), .data_in(data_in),
        .wr_evt(wr_evt), .evt_addr(evt_addr), .evt_dq(evt_dq), .rd_end(rd_end)
    );

    eep_page_ctrl #(.ROW_W(ROW_W), .PAGE_W(PAGE_W), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .evt_addr(evt_addr), .evt_dq(evt_dq),
        .rd_end(rd_end), .st(st), .cur_row(cur_row), .mask(mask), .pbuf(pbuf),
        .last_b7(last_b7), .tog(tog), .commit(commit), .accept(accept)
    );

    eep_array #(.ROW_W(ROW_W), .PAGE_W(PAGE_W)) u_arr (
        .clk(clk), .commit(commit), .row(cur_row), .mask(mask), .pbuf(pbuf),
        .rd_addr(bus_addr), .rd_data(arr_q)
    );

    assign data_drive = !chip_sel_n && wr_en_n && !out_en_n;
    assign data_out   = (st == S_PROG) ? {~last_b7, tog, 6'b0} : arr_q;
endmodule

// File: rtl/eep_page_emu_chk.sv
module eep_page_emu_chk
    import eep_pkg::*;
#(
    parameter int PAGE_N = 64,
    parameter int ROW_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel_n,
    input logic              data_drive,
    input logic [7:0]        data_out,
    input eep_state_e        st,
    input logic              wr_evt,
    input logic              accept,
    input logic              rd_end,
    input logic              tog,
    input logic [PAGE_N-1:0] mask,
    input logic [ROW_W-1:0]  cur_row
);
    assert_no_drive_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n |-> !data_drive);

    assert_first_byte_opens_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && wr_evt) |=> (st == S_LOAD));

    assert_status_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PROG && data_drive) |-> (data_out[5:0] == 6'd0));

    assert_toggle_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PROG && rd_end) |=> (tog != $past(tog)));

    assert_mask_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> (mask == '0));

    assert_foreign_row_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LOAD && wr_evt && !accept) |=> ($stable(mask) && $stable(cur_row)));

    assert_prog_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PROG && wr_evt) |=> ((mask == '0) || ($stable(mask) && $stable(cur_row))));
endmodule

bind eep_page_emu eep_page_emu_chk #(.PAGE_N(PAGE_N), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .data_drive(data_drive),
    .data_out(data_out), .st(st), .wr_evt(wr_evt), .accept(accept), .rd_end(rd_end),
    .tog(tog), .mask(mask), .cur_row(cur_row)
);

// File: tb/sim_eep_page_emu.sv
module sim_eep_page_emu;
    localparam int ROW_W  = 5;
    localparam int ADDR_W = ROW_W + 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NROWS  = 1 << ROW_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic drive;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    eep_page_emu #(.ROW_W(ROW_W), .LOAD_CYC(20), .PROG_CYC(40)) u0 (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(cs_n), .wr_en_n(we_n), .out_en_n(oe_n),
        .bus_addr(addr), .data_in(din), .data_out(dout), .data_drive(drive)
    );

    function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ {a[10:8], 5'd0} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] status_exp(input logic b7, input logic t);
        return {~b7, t, 6'd0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ce_ctl=1: strobe ended by select rising (R3)
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit ce_ctl);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        if (ce_ctl) cs_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] q);
        @(negedge clk);
        addr = a; we_n = 1'b1; cs_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 drive", drive, 1'b1);
        q = dout;
        oe_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] q;
        logic [ADDR_W-1:0] a;
        logic [7:0] pend [64];
        bit         pv   [64];
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle no drive", drive, 1'b0);

        // R2 control combinations
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; @(negedge clk);
        check("R2 select high", drive, 1'b0);
        cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; @(negedge clk);
        check("R2 we/oe high", drive, 1'b0);
        cs_n = 1'b1; oe_n = 1'b1; @(negedge clk);

        // Preload: full 64-byte pages on every row (R4), alternating strobe styles (R3)
        for (int r = 0; r < NROWS; r++) begin
            for (int c = 0; c < 64; c++) begin
                a = ADDR_W'((r << 6) | c);
                bus_write(a, pat(a), c[0]);
                model[a] = pat(a);
            end
            wait_cyc(75);
        end
        for (int c = 0; c < 64; c++) begin
            bus_read(ADDR_W'(c), q);
            check("R4 full page row0", q, model[c]);
            bus_read(ADDR_W'(((NROWS - 1) << 6) | c), q);
            check("R3 R4 full page last row", q, model[((NROWS - 1) << 6) | c]);
        end

        // Random page writes mixed with stray and late writes
        for (int it = 0; it < 24; it++) begin
            int unsigned row  = $urandom_range(NROWS - 1);
            int unsigned n    = (it == 0) ? 1 : $urandom_range(8, 1);
            bit          stray = (it % 3 == 1) || ($urandom_range(3) == 0);
            bit          late  = (it % 3 == 2) || ($urandom_range(3) == 0);
            logic [ADDR_W-1:0] sa, la;
            logic [7:0] lastd;
            logic [7:0] sold, lold;
            for (int c = 0; c < 64; c++) pv[c] = 1'b0;
            sa = ADDR_W'((((row + 1) % NROWS) << 6) | $urandom_range(63));
            la = ADDR_W'((row << 6) | $urandom_range(63));
            sold = model[sa];
            for (int k = 0; k < int'(n); k++) begin
                int unsigned c = $urandom_range(63);
                logic [7:0] d = 8'($urandom);
                if (it == 2) d = 8'h80;
                if (it == 3) d = 8'h01;
                bus_write(ADDR_W'((row << 6) | c), d, bit'($urandom_range(1)));
                pend[c] = d; pv[c] = 1'b1; lastd = d;
                if (k == 0 && stray) bus_write(sa, ~sold, 1'b0);
            end
            // still loading: old data visible (R5)
            begin
                int unsigned c0 = 0;
                for (int c = 0; c < 64; c++) if (pv[c]) c0 = c;
                bus_read(ADDR_W'((row << 6) | c0), q);
                check("R5 old data during load", q, model[(row << 6) | c0]);
            end
            wait_cyc(18);
            bus_read(la, q);
            check("R6 R7 first status", q, status_exp(lastd[7], 1'b0));
            lold = pv[la[5:0]] ? pend[la[5:0]] : model[la];
            if (late) bus_write(la, ~lold, 1'b1);
            bus_read(la, q);
            check("R6 R7 second status", q, status_exp(lastd[7], 1'b1));
            bus_read(la, q);
            check("R7 third status", q, status_exp(lastd[7], 1'b0));
            wait_cyc(40);
            for (int c = 0; c < 64; c++) if (pv[c]) model[(row << 6) | c] = pend[c];
            for (int c = 0; c < 64; c++) begin
                if (pv[c]) begin
                    bus_read(ADDR_W'((row << 6) | c), q);
                    check("R4 R8 committed byte", q, model[(row << 6) | c]);
                end
            end
            if (stray) begin
                bus_read(sa, q);
                check("R9 foreign row unchanged", q, model[sa]);
            end
            if (late) begin
                bus_read(la, q);
                check("R10 late write ignored", q, model[la]);
            end
            // untouched neighbour in the same row stays (R8 buffer cleared)
            begin
                int unsigned c1 = 64;
                for (int c = 63; c >= 0; c--) if (!pv[c]) c1 = c;
                if (c1 < 64) begin
                    bus_read(ADDR_W'((row << 6) | c1), q);
                    check("R8 unloaded byte unchanged", q, model[(row << 6) | c1]);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule